// File: doc/BRIEF.md
# Vector Byte-Lane Variable Left Shifter

This execution unit takes a 128-bit data vector and a 128-bit shift-control vector. It splits both into sixteen byte lanes and shifts each data lane left by its own amount, from zero to seven bits. The bits that enter at the bottom of a lane are not zeros. They are the top bits of the next lane toward the least significant end of the vector. Lane 0 is the most significant byte. The last lane, lane 15, has no neighbour, so zeros enter it. Every lane reads the original, unshifted operand, so no lane's result depends on another lane's result.

The operation starts with an input strobe and a 32-bit instruction word. The unit decodes the word itself and accepts only the encoding that belongs to it. A feature-enable input decides whether that encoding is allowed. If the encoding is allowed, a registered result and a result-valid pulse appear one clock later. If the encoding matches but the feature is disabled, an illegal-operation pulse appears instead and the result register is not written. Any other instruction word is ignored.

Top module: `vbyte_lshift_unit`

## Requirements
- R1: A synchronous active-high reset clears `resValid`, `illegal` and `result` at the next rising edge.
- R2: When `inValid` is high with a matching instruction and `featEn` high, `resValid` is high and `result` holds the new value after the next rising edge. In every other cycle `resValid` is low.
- R3: The shift count of lane i is bits [2:0] of control byte i. Bits [7:3] of that control byte have no effect on the result.
- R4: Byte i of the result is bits [15:8] of the 16-bit value {data byte i, data byte i+1} shifted left by the lane's count. Byte i occupies bits [127-8i : 120-8i].
- R5: Lane 15 uses zero as its lower half. The low `count` bits of result byte 15 are therefore always zero.
- R6: An instruction matches only when bits [31:26] equal 4 and bits [10:0] equal 0x744. Bits [5:1] hold 2, bit 0 is 0 and bits [10:6] hold 29. A non-matching word raises neither flag and leaves `result` unchanged.
- R7: A matching instruction with `featEn` low pulses `illegal` one cycle later, keeps `resValid` low and leaves `result` unchanged. `illegal` and `resValid` are never high together.
- R8: A count of 0 in every lane returns the data operand unchanged. A count of 7 in a lane gives {bit 0 of byte i, bits [7:1] of byte i+1}.
- R9: With `inValid` low, `result` holds its value and neither flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation request strobe |
| instr | input | 32 | Instruction word to decode |
| featEn | input | 1 | Feature level enable; a matching op is legal only when high |
| dataIn | input | 128 | Data vector, byte 0 in bits [127:120] |
| ctrlIn | input | 128 | Shift-control vector, one count per byte |
| resValid | output | 1 | Result valid, one cycle after an accepted op |
| result | output | 128 | Registered shifted vector |
| illegal | output | 1 | Pulse for a matching op with the feature disabled |

## Verification
The hardest case to reach from the ports is a lane whose incoming bits must come from the neighbouring byte while that lane's own control byte also carries junk in its upper bits. Random control bytes almost never combine both with the extreme counts. Directed vectors therefore set all control bytes to 0xF8|count with counts of 0 and 7, and they use an all-ones data pattern so that the zero fill of lane 15 is visible. Near-miss instruction words, with one field wrong, are sent between legal operations, so that a write that should not happen would change a known result.

// File: rtl/vbyte_lshift_pkg.sv
package vbyte_lshift_pkg;
  localparam int VEC_W  = 128;
  localparam int LANE_W = 8;
  localparam int INSTR_W = 32;

  typedef struct packed {
    logic load;
    logic flagIllegal;
  } ctrlStrobes_t;
endpackage

// File: rtl/vbyte_lshift_ctrl.sv
module vbyte_lshift_ctrl
  import vbyte_lshift_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W,
  parameter int PRIMARY_OPC = 4,
  parameter int EXT_OPC     = 'h744
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [INSTR_WIDTH-1:0] instr,
  input  logic                   featEn,
  output ctrlStrobes_t           strb,
  output logic                   resValid,
  output logic                   illegal
);
  localparam int OPC_W = 6;
  localparam int XO_W  = 11;

  logic opcHit;
  logic xoHit;
  logic isMine;

  assign opcHit = instr[INSTR_WIDTH-1 -: OPC_W] == OPC_W'(PRIMARY_OPC);
  assign xoHit  = instr[XO_W-1:0] == XO_W'(EXT_OPC);
  assign isMine = inValid && opcHit && xoHit;

  always_comb begin
    strb.load        = isMine && featEn;
    strb.flagIllegal = isMine && !featEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= strb.load;
      illegal  <= strb.flagIllegal;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!resValid && !illegal));
  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcHit && xoHit && featEn) |=> resValid);
  // R6
  a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
    (!(opcHit && xoHit)) |=> (!resValid && !illegal));
  // R7
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegal));
  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!resValid && !illegal));
endmodule

// File: rtl/vbyte_lshift_datapath.sv
module vbyte_lshift_datapath
  import vbyte_lshift_pkg::*;
#(
  parameter int VEC_WIDTH  = VEC_W,
  parameter int LANE_WIDTH = LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strb,
  input  logic [VEC_WIDTH-1:0] dataIn,
  input  logic [VEC_WIDTH-1:0] ctrlIn,
  output logic [VEC_WIDTH-1:0] result
);
  localparam int LANES = VEC_WIDTH / LANE_WIDTH;
  localparam int CNT_W = $clog2(LANE_WIDTH);

  logic [VEC_WIDTH-1:0] laneRes;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = VEC_WIDTH - 1 - i * LANE_WIDTH;
    logic [LANE_WIDTH-1:0]   curByte;
    logic [LANE_WIDTH-1:0]   nextByte;
    logic [CNT_W-1:0]        amt;
    logic [2*LANE_WIDTH-1:0] pair;

    assign curByte = dataIn[HI -: LANE_WIDTH];
    if (i == LANES - 1) begin : g_last
      assign nextByte = '0;
    end else begin : g_mid
      assign nextByte = dataIn[HI-LANE_WIDTH -: LANE_WIDTH];
    end
    assign amt  = ctrlIn[HI-LANE_WIDTH+1 +: CNT_W];
    assign pair = {curByte, nextByte} << amt;
    assign laneRes[HI -: LANE_WIDTH] = pair[2*LANE_WIDTH-1 -: LANE_WIDTH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strb.load) begin
      result <= laneRes;
    end
  end

  // R7 / R9: nothing but an accepted op writes the result
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(result));
  // R5: low bits of the last lane come only from zero fill
  a_r5_last_fill: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> ((result[LANE_WIDTH-1:0] &
      ((LANE_WIDTH'(1) << $past(ctrlIn[CNT_W-1:0])) - LANE_WIDTH'(1))) == '0));
endmodule

// File: rtl/vbyte_lshift_unit.sv
module vbyte_lshift_unit
  import vbyte_lshift_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [31:0]  instr,
  input  logic         featEn,
  input  logic [127:0] dataIn,
  input  logic [127:0] ctrlIn,
  output logic         resValid,
  output logic [127:0] result,
  output logic         illegal
);
  ctrlStrobes_t strb;

  vbyte_lshift_ctrl #(
    .INSTR_WIDTH(INSTR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .featEn(featEn),
    .strb(strb), .resValid(resValid), .illegal(illegal)
  );

  vbyte_lshift_datapath #(
    .VEC_WIDTH(VEC_W), .LANE_WIDTH(LANE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(dataIn), .ctrlIn(ctrlIn),
    .result(result)
  );
endmodule

// File: tb/vbyte_lshift_unit_bench.sv
module vbyte_lshift_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [31:0]  instr;
  logic         featEn;
  logic [127:0] dataIn;
  logic [127:0] ctrlIn;
  logic         resValid;
  logic [127:0] result;
  logic         illegal;

  int checks = 0;
  int fails  = 0;
  logic [127:0] lastRes;

  localparam logic [31:0] GOOD = 32'h1000_0744;

  always #5 clk = ~clk;

  vbyte_lshift_unit u_vbyte_lshift_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr), .featEn(featEn),
    .dataIn(dataIn), .ctrlIn(ctrlIn), .resValid(resValid), .result(result),
    .illegal(illegal)
  );

  function automatic logic [127:0] refModel(input logic [127:0] d, input logic [127:0] c);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  a;
      logic [7:0]  b;
      logic [15:0] w;
      a = d[127-8*i -: 8];
      b = (i == 15) ? 8'h00 : d[119-8*i -: 8];
      w = {a, b};
      w = w << c[120-8*i +: 3];
      r[127-8*i -: 8] = w[15:8];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one op at negedge, sample at the following negedge
  task automatic issue(input logic v, input logic [31:0] ins, input logic fe,
                       input logic [127:0] d, input logic [127:0] c);
    inValid = v; instr = ins; featEn = fe; dataIn = d; ctrlIn = c;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic legalOp(input string tag, input logic [127:0] d, input logic [127:0] c);
    logic [127:0] e;
    e = refModel(d, c);
    issue(1'b1, GOOD, 1'b1, d, c);
    check({tag, " R2 valid"}, {127'd0, resValid}, 128'd1);
    check({tag, " R7 no illegal"}, {127'd0, illegal}, 128'd0);
    check({tag, " R4 data"}, result, e);
    lastRes = result;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] d;
    logic [127:0] c;
    void'($urandom(32'd1234));
    rst = 1'b1; inValid = 0; instr = 0; featEn = 0; dataIn = 0; ctrlIn = 0;
    @(negedge clk); @(negedge clk);
    check("R1 resValid", {127'd0, resValid}, 128'd0);
    check("R1 illegal", {127'd0, illegal}, 128'd0);
    check("R1 result", result, 128'd0);
    rst = 1'b0;

    d = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    // R8 shift 0 identity, upper control bits set (R3)
    legalOp("R8 zero", d, 128'h0);
    check("R8 identity", result, d);
    legalOp("R3 junk-high zero", d, {16{8'hF8}});
    check("R3 high bits ignored", result, d);
    // R8 shift 7
    legalOp("R8 seven", d, {16{8'h07}});
    legalOp("R3 junk-high seven", d, {16{8'hFF}});
    // R5 lane 15 fill with all ones
    legalOp("R5 ones", {128{1'b1}}, {16{8'h03}});
    check("R5 last lane", {120'd0, result[7:0]}, 128'hF8);
    legalOp("R5 ones seven", {128{1'b1}}, {16{8'h07}});
    check("R5 last lane 7", {120'd0, result[7:0]}, 128'h80);
    // per-lane distinct counts
    legalOp("R4 ramp", d, 128'h0001_0203_0405_0607_0001_0203_0405_0607);

    // R7 feature disabled
    issue(1'b1, GOOD, 1'b0, ~d, {16{8'h05}});
    check("R7 illegal pulse", {127'd0, illegal}, 128'd1);
    check("R7 no valid", {127'd0, resValid}, 128'd0);
    check("R7 result held", result, lastRes);
    @(negedge clk);
    check("R7 illegal one cycle", {127'd0, illegal}, 128'd0);

    // R6 near-miss encodings
    issue(1'b1, 32'h1400_0744, 1'b1, ~d, {16{8'h05}});
    check("R6 opcode miss valid", {127'd0, resValid}, 128'd0);
    check("R6 opcode miss illegal", {127'd0, illegal}, 128'd0);
    check("R6 opcode miss result", result, lastRes);
    issue(1'b1, 32'h1000_0745, 1'b1, ~d, {16{8'h05}});
    check("R6 bit0 miss valid", {127'd0, resValid}, 128'd0);
    check("R6 bit0 miss result", result, lastRes);
    issue(1'b1, 32'h1000_0704, 1'b0, ~d, {16{8'h05}});
    check("R6 sub miss illegal", {127'd0, illegal}, 128'd0);
    check("R6 sub miss result", result, lastRes);
    issue(1'b1, 32'hFFFF_F744 & 32'h13FF_F744, 1'b1, ~d, {16{8'h05}});
    check("R6 middle bits free", {127'd0, resValid}, 128'd1);
    check("R6 middle bits result", result, refModel(~d, {16{8'h05}}));
    lastRes = result;

    // R9 idle
    issue(1'b0, GOOD, 1'b1, d, {16{8'h01}});
    check("R9 idle valid", {127'd0, resValid}, 128'd0);
    check("R9 idle result", result, lastRes);

    // R2 back-to-back and random
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < 4; k++) begin
        d[32*k +: 32] = $urandom;
        c[32*k +: 32] = $urandom;
      end
      legalOp("R4 random", d, c);
    end

    @(negedge clk);
    check("R2 valid drops", {127'd0, resValid}, 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule